// File: doc/BRIEF.md
# Aligned Fragment Trailer Builder

This block sits on a byte stream that carries event fragments. Each fragment arrives framed by a start marker on its first byte and an end marker on its last byte. Its final two bytes are a short trailer that an upstream stage appended. That short trailer leaves the fragment two bytes past a 16-byte boundary. The block keeps every byte ahead of the short trailer as payload and passes it through unchanged. It takes the short trailer out of the data path and closes the fragment with a 16-byte trailer of its own, so the output again ends on a 16-byte boundary.

The new trailer holds several fields:

- the two received trailer bytes;
- two zero spare bytes;
- the byte offset of the first byte flagged with a receive error;
- an XOR parity over every byte received for the fragment, the short trailer included;
- a status byte that flags receive errors and fragments too short to hold a trailer.

A two-byte delay line holds back the newest bytes. That is how the short trailer is recognised once the end marker shows up.

The source must leave at least 16 idle cycles after each end marker, because the block has no back-pressure. It emits the trailer during those cycles.

Top module: `trailer_wrap16`

## Requirements
- R1: After synchronous reset, out_valid, out_sof and out_eof stay low until a fragment is received.
- R2: For a fragment of L bytes, the first L-2 received bytes come out unchanged and in order as payload. out_sof is high on the first output byte of each fragment and low on every other byte.
- R3: For L >= 2 a fragment produces exactly L-2+16 output bytes; for L = 1 it produces 16. out_eof is high only on the last of them, trailer byte 15.
- R4: Trailer bytes 0 and 1 are the second-to-last and last received bytes. For L = 1, byte 0 is zero and byte 1 is the single received byte.
- R5: Trailer bytes 2 and 3 are zero.
- R6: Trailer bytes 4 (low) and 5 (high) hold the 0-based offset within the fragment of the first byte received with in_rx_err high. Both are zero if no byte had an error. Bytes 6 to 13 are zero.
- R7: Trailer byte 14 is the XOR of all L received bytes of the fragment.
- R8: Trailer byte 15 has bit 7 set if any received byte had in_rx_err high, and bit 6 set if L < 2. Bits 5 to 0 are zero.
- R9: Trailer byte 0 is on the output two cycles after the clock edge that samples the end-marked input byte. The 16 trailer bytes then follow on consecutive cycles, so out_eof is high 17 cycles after that edge.
- R10: After an end-marked byte, in_valid stays low for at least 16 cycles (a rule on the source).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present this cycle |
| in_sof | input | 1 | Input byte is the first of a fragment |
| in_eof | input | 1 | Input byte is the last of a fragment |
| in_data | input | 8 | Input byte |
| in_rx_err | input | 1 | Receive error flagged on this input byte |
| out_valid | output | 1 | Output byte present this cycle |
| out_sof | output | 1 | Output byte is the first of a fragment |
| out_eof | output | 1 | Output byte is the last trailer byte |
| out_data | output | 8 | Output byte |

## Verification
The bench sweeps fragment lengths from one byte upward, under back-to-back and spaced input. It targets the short cases: at L = 1 and L = 2 there is no payload, so a design that miscounts its delay line would leak trailer bytes as payload or drop the start flag. Single errors are placed on every offset, the first byte and the trailer bytes included. A design that recorded the last error instead of the first, or counted offsets from one, would put wrong values in bytes 4 and 5. Parity is compared over fragments whose trailer bytes vary, which catches a parity that leaves out the short trailer. The end flag is timed against the end-marked input, so a trailer that starts one cycle late or skips a byte is caught.

// File: rtl/tw16_pkg.sv
package tw16_pkg;

    localparam int BYTE_W  = 8;
    localparam int TRL_LEN = 16;
    localparam int IDX_W   = $clog2(TRL_LEN);
    localparam int OFS_W   = 16;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [OFS_W-1:0]  ofs_t;
    typedef logic [IDX_W-1:0]  tidx_t;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_TRL  = 1'b1
    } phase_t;

    // Everything needed to build the aligned trailer of one fragment.
    typedef struct packed {
        byte_t lead0;
        byte_t lead1;
        ofs_t  err_ofs;
        byte_t parity;
        logic  any_err;
        logic  short_frag;
    } trl_info_t;

    function automatic byte_t trl_byte(input trl_info_t t, input tidx_t idx);
        byte_t b;
        case (idx)
            tidx_t'(0):  b = t.lead0;
            tidx_t'(1):  b = t.lead1;
            tidx_t'(4):  b = t.err_ofs[7:0];
            tidx_t'(5):  b = t.err_ofs[15:8];
            tidx_t'(14): b = t.parity;
            tidx_t'(15): b = {t.any_err, t.short_frag, 6'b0};
            default:     b = '0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/tw16_delay.sv
module tw16_delay
    import tw16_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  logic  in_sof,
    input  logic  in_eof,
    input  byte_t in_data,
    output logic  pay_valid,
    output byte_t pay_data,
    output byte_t lead0,
    output byte_t lead1,
    output logic  short_frag
);
    localparam int HOLD = 2;
    localparam int CNT_W = $clog2(HOLD + 1);

    byte_t             hold_q [HOLD];
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_eff;

    // A start marker restarts the line even if the previous end was lost.
    assign cnt_eff    = in_sof ? '0 : cnt_q;
    assign pay_valid  = in_valid && (cnt_eff == CNT_W'(HOLD));
    assign pay_data   = hold_q[0];
    assign lead0      = (cnt_eff != '0) ? hold_q[HOLD-1] : '0;
    assign lead1      = in_data;
    assign short_frag = (cnt_eff == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            for (int i = 0; i < HOLD; i++) hold_q[i] <= '0;
        end else if (in_valid) begin
            if (in_eof) begin
                cnt_q <= '0;
            end else begin
                for (int i = 0; i < HOLD - 1; i++) hold_q[i] <= hold_q[i+1];
                hold_q[HOLD-1] <= in_data;
                cnt_q <= (cnt_eff == CNT_W'(HOLD)) ? cnt_eff : cnt_eff + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tw16_accum.sv
module tw16_accum
    import tw16_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  logic  in_sof,
    input  byte_t in_data,
    input  logic  in_rx_err,
    output byte_t parity,
    output logic  any_err,
    output ofs_t  err_ofs
);
    byte_t par_q;
    logic  err_q;
    ofs_t  first_q;
    ofs_t  pos_q;

    byte_t par_base;
    logic  err_base;
    ofs_t  pos_cur;

    assign par_base = in_sof ? '0 : par_q;
    assign err_base = in_sof ? 1'b0 : err_q;
    assign pos_cur  = in_sof ? '0 : pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            par_q   <= '0;
            err_q   <= 1'b0;
            first_q <= '0;
            pos_q   <= '0;
        end else if (in_valid) begin
            par_q <= par_base ^ in_data;
            err_q <= err_base | in_rx_err;
            if (in_rx_err && !err_base)
                first_q <= pos_cur;
            else if (in_sof)
                first_q <= '0;
            pos_q <= (pos_cur == '1) ? pos_cur : pos_cur + 1'b1;
        end
    end

    assign parity  = par_q;
    assign any_err = err_q;
    assign err_ofs = err_q ? first_q : '0;

endmodule

// File: rtl/tw16_emit.sv
module tw16_emit
    import tw16_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sof_seen,
    input  logic  eof_seen,
    input  logic  pay_valid,
    input  byte_t pay_data,
    input  byte_t lead0,
    input  byte_t lead1,
    input  logic  short_frag,
    input  byte_t parity,
    input  logic  any_err,
    input  ofs_t  err_ofs,
    output logic  out_valid,
    output logic  out_sof,
    output logic  out_eof,
    output byte_t out_data
);
    phase_t    phase_q;
    tidx_t     idx_q;
    byte_t     lead0_q;
    byte_t     lead1_q;
    logic      short_q;
    logic      sof_pend_q;
    trl_info_t info;

    assign info = '{lead0: lead0_q, lead1: lead1_q, err_ofs: err_ofs,
                    parity: parity, any_err: any_err, short_frag: short_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            idx_q      <= '0;
            lead0_q    <= '0;
            lead1_q    <= '0;
            short_q    <= 1'b0;
            sof_pend_q <= 1'b0;
            out_valid  <= 1'b0;
            out_sof    <= 1'b0;
            out_eof    <= 1'b0;
            out_data   <= '0;
        end else begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;

            if (eof_seen) begin
                lead0_q <= lead0;
                lead1_q <= lead1;
                short_q <= short_frag;
                phase_q <= PH_TRL;
                idx_q   <= '0;
            end

            if (pay_valid) begin
                out_valid <= 1'b1;
                out_data  <= pay_data;
                out_sof   <= sof_pend_q;
            end else if (phase_q == PH_TRL) begin
                out_valid <= 1'b1;
                out_data  <= trl_byte(info, idx_q);
                out_sof   <= sof_pend_q;
                out_eof   <= (idx_q == tidx_t'(TRL_LEN - 1));
                idx_q     <= idx_q + 1'b1;
                if (idx_q == tidx_t'(TRL_LEN - 1))
                    phase_q <= PH_IDLE;
            end

            if (sof_seen)
                sof_pend_q <= 1'b1;
            else if (pay_valid || phase_q == PH_TRL)
                sof_pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/trailer_wrap16.sv
module trailer_wrap16
    import tw16_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_sof,
    input  logic       in_eof,
    input  logic [7:0] in_data,
    input  logic       in_rx_err,
    output logic       out_valid,
    output logic       out_sof,
    output logic       out_eof,
    output logic [7:0] out_data
);
    logic  pay_valid;
    byte_t pay_data;
    byte_t lead0;
    byte_t lead1;
    logic  short_frag;
    byte_t parity;
    logic  any_err;
    ofs_t  err_ofs;

    tw16_delay u_delay (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .pay_valid(pay_valid), .pay_data(pay_data),
        .lead0(lead0), .lead1(lead1), .short_frag(short_frag)
    );

    tw16_accum u_accum (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data), .in_rx_err(in_rx_err),
        .parity(parity), .any_err(any_err), .err_ofs(err_ofs)
    );

    tw16_emit u_emit (
        .clk(clk), .rst(rst),
        .sof_seen(in_valid && in_sof), .eof_seen(in_valid && in_eof),
        .pay_valid(pay_valid), .pay_data(pay_data),
        .lead0(lead0), .lead1(lead1), .short_frag(short_frag),
        .parity(parity), .any_err(any_err), .err_ofs(err_ofs),
        .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof), .out_data(out_data)
    );

endmodule

// File: rtl/tw16_checker.sv
module tw16_checker (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_eof,
    input logic       out_valid,
    input logic       out_sof,
    input logic       out_eof,
    input logic [7:0] out_data
);
    logic [4:0] gap_q;
    logic [4:0] since_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q   <= '0;
            since_q <= '1;
        end else begin
            if (in_valid && in_eof) begin
                gap_q   <= 5'd16;
                since_q <= '0;
            end else begin
                if (gap_q != '0) gap_q <= gap_q - 1'b1;
                if (since_q != '1) since_q <= since_q + 1'b1;
            end
        end
    end

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid && !out_sof && !out_eof);

    p_sof_needs_valid_r2: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> out_valid);

    p_eof_needs_valid_r3: assert property (@(posedge clk) disable iff (rst)
        out_eof |-> out_valid);

    p_status_low_bits_r8: assert property (@(posedge clk) disable iff (rst)
        out_eof |-> out_data[5:0] == 6'b0);

    p_trailer_start_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_eof) |=> ##1 out_valid);

    p_eof_timing_r9: assert property (@(posedge clk) disable iff (rst)
        out_eof |-> since_q == 5'd16);

    p_idle_gap_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> gap_q == '0);

endmodule

bind trailer_wrap16 tw16_checker u_tw16_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_eof(in_eof),
    .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof), .out_data(out_data)
);

// File: tb/sim_trailer_wrap16.sv
`timescale 1ns/1ps
module sim_trailer_wrap16;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid, in_sof, in_eof, in_rx_err;
    logic [7:0] in_data;
    logic       out_valid, out_sof, out_eof;
    logic [7:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int eof_in_cyc;
    int eof_out_cyc;
    bit done     = 1'b0;

    logic [9:0] got[$];
    logic [9:0] exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    trailer_wrap16 u0 (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_data(in_data), .in_rx_err(in_rx_err),
        .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof), .out_data(out_data)
    );

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            got.push_back({out_sof, out_eof, out_data});
            if (out_eof) eof_out_cyc = cyc;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    function automatic string req_of(input int pos, input int npay);
        int k;
        if (pos < npay) return "R2 payload";
        k = pos - npay;
        if (k <= 1)  return "R4 received trailer";
        if (k <= 3)  return "R5 spare bytes";
        if (k <= 13) return "R6 error location";
        if (k == 14) return "R7 parity";
        return "R8 status";
    endfunction

    // Sends one fragment of len bytes; err_at/err_at2 < 0 means no error there.
    task automatic run_frag(input int len, input int err_at, input int err_at2,
                            input int spacing, input int seed);
        logic [7:0] d [];
        bit         e [];
        logic [7:0] par;
        bit         anye;
        int         first;
        int         npay;
        d = new[len];
        e = new[len];
        par = 8'h00; anye = 1'b0; first = 0;
        for (int i = 0; i < len; i++) begin
            d[i] = 8'((seed * 31 + i * 73 + len * 5 + 17) & 8'hFF);
            e[i] = (i == err_at) || (i == err_at2);
            par ^= d[i];
            if (e[i] && !anye) begin anye = 1'b1; first = i; end
        end
        npay = (len >= 2) ? len - 2 : 0;
        exp_q.delete();
        got.delete();
        for (int i = 0; i < npay; i++)
            exp_q.push_back({(i == 0), 1'b0, d[i]});
        for (int k = 0; k < 16; k++) begin
            logic [7:0] b;
            case (k)
                0:  b = (len >= 2) ? d[len-2] : 8'h00;
                1:  b = d[len-1];
                4:  b = 8'(first & 8'hFF);
                5:  b = 8'((first >> 8) & 8'hFF);
                14: b = par;
                15: b = {anye, (len < 2), 6'b0};
                default: b = 8'h00;
            endcase
            exp_q.push_back({(npay == 0 && k == 0), (k == 15), b});
        end

        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid  = 1'b1;
            in_sof    = (i == 0);
            in_eof    = (i == len - 1);
            in_data   = d[i];
            in_rx_err = e[i];
            if (i == len - 1) begin
                @(negedge clk);
                eof_in_cyc = cyc;
            end else begin
                for (int s = 1; s < spacing; s++) begin
                    @(negedge clk);
                    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_rx_err = 1'b0;
                end
            end
            if (i == len - 1 || spacing > 1) begin
                in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_rx_err = 1'b0;
            end
        end
        repeat (20) @(negedge clk);

        // R3: total output length and end flag position.
        check(got.size() == exp_q.size(), "R3 output length", got.size(), exp_q.size());
        if (got.size() == exp_q.size()) begin
            for (int p = 0; p < exp_q.size(); p++)
                check(got[p] == exp_q[p], req_of(p, npay), got[p], exp_q[p]);
            // R9: out_eof is 16 negedge samples after the end-marked byte was taken.
            check(eof_out_cyc - eof_in_cyc == 16, "R9 trailer timing",
                  eof_out_cyc - eof_in_cyc, 16);
        end
    endtask

    initial begin
        rst = 1'b1;
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h00; in_rx_err = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(!out_valid && !out_sof && !out_eof, "R1 quiet after reset",
                  {out_valid, out_sof, out_eof}, 0);
        end

        // Length sweep, no errors, back-to-back bytes (R2, R3, R4, R5, R7, R8).
        for (int len = 1; len <= 36; len++) run_frag(len, -1, -1, 1, len);
        // Same sweep with spaced bytes.
        for (int len = 1; len <= 20; len++) run_frag(len, -1, -1, 3, len + 100);
        // Single error at every offset, trailer bytes included (R6, R8).
        for (int len = 1; len <= 18; len += 17)
            for (int ea = 0; ea < len; ea++) run_frag(len, ea, -1, 1, ea + 7);
        for (int ea = 0; ea < 5; ea++) run_frag(5, ea, -1, 2, ea + 50);
        // Two errors: the first one is recorded (R6).
        run_frag(20, 3, 7, 1, 9);
        run_frag(20, 19, 11, 1, 10);
        run_frag(2, 0, 1, 1, 11);
        // Long fragment so the offset's high byte is non-zero (R6).
        run_frag(300, 290, -1, 1, 12);

        done = 1'b1;
        finish_run();
    end

    initial begin
        while (cyc < 150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

endmodule